// File: doc/BRIEF.md
# Backplane Broadcast Slave Controller

This block is the slave-side control logic of a module sitting on a shared, multi-module backplane bus. During an address cycle it latches a broadcast command code. On the data cycle that follows, it acts on that code. It may select the module for later data cycles. It may drive the shared trigger-pattern line, either unconditionally or depending on local data or a service request. On a write, it may select itself when its own pattern line is asserted.

The block returns a 3-bit slave status code on every data cycle. The status covers plain data cycles addressed to the selected module and broadcast follow-up cycles. Electrical arbitration and the data path sit outside this block. The strobes `addr_cyc` and `data_cyc` are one-cycle pulses, and they never occur in the same cycle. The outputs `pat_drive` and `status` are combinational during the data-cycle pulse. `selected` is registered.

Top module: `bcast_slave`

## Requirements
- R1: An address cycle with code 0x01 sets `selected` from the next clock edge. It stays set across later data cycles until the next address cycle or reset.
- R2: After code 0x09, a read data cycle drives `pat_drive` high exactly when `has_data` is high. The status is 0.
- R3: After code 0x09, a write data cycle sets `selected` to the value of `pat_in` sampled in that cycle. The status is 0 and `pat_drive` stays low.
- R4: After code 0x0D, a read data cycle drives `pat_drive` high regardless of `has_data`.
- R5: After code 0xCD, a read data cycle drives `pat_drive` high exactly when `svc_req` is high.
- R6: After code 0x9D, a read data cycle drives `pat_drive` high only under three conditions together:
  - the module belongs to the scan family (parameter `IN_FAMILY`);
  - the preceding broadcast was 0x09 followed by a read while `has_data` was high;
  - `has_data` is high now.
- R7: An address cycle with any other code clears `selected`. The next data cycle does not drive `pat_drive`.
- R8: `pat_drive` is asserted only during the first data cycle after the command. A second data cycle without a new address cycle is treated as a plain data cycle.
- R9: On a plain data cycle to a selected module, the status is chosen in this priority order:
  - 1 (busy) when `busy` is high;
  - otherwise 7 (invalid secondary address) when `addr_ok` is low;
  - otherwise 2 (end of data) on a read with `has_data` low;
  - otherwise 0 (valid).
- R10: The status is 6 (invalid mode) in two cases: a plain data cycle to an unselected module, and a write after 0x0D, 0xCD or 0x9D. Otherwise a broadcast follow-up cycle returns 0. Outside data cycles the status is 0. Codes 3, 4 and 5 never occur.
- R11: Reset, or any new address cycle, discards a pending broadcast command. After reset, `selected` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_cyc | input | 1 | Address-cycle strobe; latches `code` |
| code | input | CODE_W | Broadcast command code |
| data_cyc | input | 1 | Data-cycle strobe |
| wr | input | 1 | 1 = write data cycle, 0 = read |
| has_data | input | 1 | Module holds unread data |
| svc_req | input | 1 | Auxiliary card requests service |
| busy | input | 1 | Module cannot complete the data cycle now |
| addr_ok | input | 1 | Internal secondary address is valid |
| pat_in | input | 1 | Own pattern line as seen on the bus |
| selected | output | 1 | Module is selected for plain data cycles |
| pat_drive | output | 1 | Drive enable for the shared pattern line |
| status | output | 3 | Slave status for the current data cycle |

## Verification
Two-phase hand-off is the main target. A design that kept the pending command too long would drive the pattern line again on a second read. One that forgot to clear it on reset or on a new address cycle would answer a stale scan. The second-stage 0x9D scan is exercised three ways: with a qualifying prior scan, without any prior scan, and after a scan that found no data. Together these catch a family flag that is never set, never cleared, or set without regard to data. Status priority is stressed with busy and a bad address raised together. Broadcast writes after read-only codes are also covered; a design lacking the invalid-mode check would return valid there.

// File: rtl/bcast_slave.sv
module bcast_slave #(
  parameter int CODE_W = 8,
  parameter bit IN_FAMILY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_cyc,
  input  logic [CODE_W-1:0] code,
  input  logic              data_cyc,
  input  logic              wr,
  input  logic              has_data,
  input  logic              svc_req,
  input  logic              busy,
  input  logic              addr_ok,
  input  logic              pat_in,
  output logic              selected,
  output logic              pat_drive,
  output logic [2:0]        status
);
  localparam logic [CODE_W-1:0] C_SEL  = CODE_W'('h01);
  localparam logic [CODE_W-1:0] C_SCAN = CODE_W'('h09);
  localparam logic [CODE_W-1:0] C_ALL  = CODE_W'('h0D);
  localparam logic [CODE_W-1:0] C_FAM  = CODE_W'('h9D);
  localparam logic [CODE_W-1:0] C_SVC  = CODE_W'('hCD);

  localparam logic [2:0] ST_OK   = 3'd0;
  localparam logic [2:0] ST_BUSY = 3'd1;
  localparam logic [2:0] ST_EOD  = 3'd2;
  localparam logic [2:0] ST_MODE = 3'd6;
  localparam logic [2:0] ST_ADDR = 3'd7;

  typedef enum logic [2:0] {P_NONE, P_SCAN, P_ALL, P_SVC, P_FAM} pend_t;

  pend_t pend, pend_dec;
  logic  armed;

  always_comb begin
    pend_dec = P_NONE;
    if (code == C_SCAN) pend_dec = P_SCAN;
    else if (code == C_ALL) pend_dec = P_ALL;
    else if (code == C_SVC) pend_dec = P_SVC;
    else if (code == C_FAM && IN_FAMILY) pend_dec = P_FAM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= P_NONE;
      selected <= 1'b0;
      armed    <= 1'b0;
    end else if (addr_cyc) begin
      pend     <= pend_dec;
      selected <= (code == C_SEL);
      armed    <= armed && (pend_dec == P_FAM);
    end else if (data_cyc) begin
      pend <= P_NONE;
      if (pend == P_SCAN && wr)  selected <= pat_in;
      if (pend == P_SCAN && !wr) armed <= has_data;
      if (pend == P_FAM)         armed <= 1'b0;
    end
  end

  assign pat_drive = data_cyc && !wr &&
                     ((pend == P_SCAN && has_data) ||
                      (pend == P_ALL) ||
                      (pend == P_SVC && svc_req) ||
                      (pend == P_FAM && armed && has_data));

  always_comb begin
    status = ST_OK;
    if (data_cyc) begin
      if (pend != P_NONE)
        status = (wr && pend != P_SCAN) ? ST_MODE : ST_OK;
      else if (!selected)
        status = ST_MODE;
      else if (busy)
        status = ST_BUSY;
      else if (!addr_ok)
        status = ST_ADDR;
      else if (!wr && !has_data)
        status = ST_EOD;
    end
  end

  assert_sel_on_01_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && code == C_SEL) |=> selected);

  assert_write_scan_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr_cyc && code == C_SCAN) && data_cyc && wr) |=> (selected == $past(pat_in)));

  assert_unknown_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && code != C_SEL && code != C_SCAN && code != C_ALL &&
     code != C_SVC && code != C_FAM) |=> !selected);

  assert_single_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_drive && !addr_cyc) |=> !pat_drive);

  assert_pat_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_drive |-> (data_cyc && !wr));

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd3 && status != 3'd4 && status != 3'd5));

  assert_status_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_cyc |-> (status == 3'd0));
endmodule

// File: tb/test_bcast_slave.sv
module test_bcast_slave;
  localparam int CLK_P = 10;
  localparam int NV = 16;
  localparam int WDOG = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_cyc = 1'b0, data_cyc = 1'b0, wr = 1'b0;
  logic has_data = 1'b0, svc_req = 1'b0, busy = 1'b0, addr_ok = 1'b1, pat_in = 1'b0;
  logic [7:0] code = 8'h00;
  logic selected, pat_drive;
  logic [2:0] status;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bcast_slave i_bcast_slave (
    .clk(clk), .rst_n(rst_n), .addr_cyc(addr_cyc), .code(code),
    .data_cyc(data_cyc), .wr(wr), .has_data(has_data), .svc_req(svc_req),
    .busy(busy), .addr_ok(addr_ok), .pat_in(pat_in),
    .selected(selected), .pat_drive(pat_drive), .status(status));

  // {code, wr, has_data, svc_req, pat_in, busy, addr_ok, exp_pat, exp_status, exp_selected}
  localparam logic [18:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R1
    {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 1'b1}, // R9 end of data
    {8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1}, // R9 busy wins
    {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1}, // R9 bad address
    {8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R9 write ok
    {8'h55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 1'b0}, // R7
    {8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0}, // R2
    {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R2
    {8'h09, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R3
    {8'h09, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R3
    {8'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0}, // R4
    {8'hCD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0}, // R5
    {8'hCD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R5
    {8'h0D, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 1'b0}, // R10
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 1'b0}, // R7
    {8'h9D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}  // R6 no prior scan
  };

  function automatic string vreq(int i);
    case (i)
      0: return "R1";
      1, 2, 3, 4: return "R9";
      5, 14: return "R7";
      6, 7: return "R2";
      8, 9: return "R3";
      10: return "R4";
      11, 12: return "R5";
      13: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_addr(logic [7:0] c);
    @(negedge clk); addr_cyc = 1'b1; code = c;
    @(negedge clk); addr_cyc = 1'b0;
  endtask

  // Drives a data cycle; checks combinational outputs mid-cycle.
  task automatic do_data(string req, logic w, logic hd, logic sv, logic pi, logic bz, logic ao,
                         logic ep, logic [2:0] es);
    data_cyc = 1'b1; wr = w; has_data = hd; svc_req = sv; pat_in = pi; busy = bz; addr_ok = ao;
    #1;
    chk({req, " pattern"}, int'(pat_drive), int'(ep));
    chk({req, " status"}, int'(status), int'(es));
    @(negedge clk); data_cyc = 1'b0; busy = 1'b0; addr_ok = 1'b1;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset selected", int'(selected), 0);
    chk("R11 reset pattern", int'(pat_drive), 0);
    chk("R10 idle status", int'(status), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      do_addr(v[18:11]);
      do_data(vreq(i), v[10], v[9], v[8], v[7], v[6], v[5], v[4], v[3:1]);
      #1;
      chk({vreq(i), " selected"}, int'(selected), int'(v[0]));
    end

    // R8: second read after an unconditional scan is a plain cycle
    do_addr(8'h0D);
    do_data("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    do_data("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6);

    // R6: qualifying scan then second stage
    do_addr(8'h09);
    do_data("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    do_addr(8'h9D);
    do_data("R6 armed", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    do_addr(8'h9D);
    do_data("R6 consumed", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    // R6: scan with no data does not arm
    do_addr(8'h09);
    do_data("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    do_addr(8'h9D);
    do_data("R6 empty scan", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    // R6: intervening address cycle disarms
    do_addr(8'h09);
    do_data("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    do_addr(8'h01);
    do_addr(8'h9D);
    do_data("R6 disarmed", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    // R10: write after second-stage code
    do_addr(8'h9D);
    do_data("R10 write after 9D", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6);

    // R11: new address cycle discards pending command
    do_addr(8'h0D);
    do_addr(8'h55);
    do_data("R11 replaced", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6);
    // R11: reset discards pending command and selection
    do_addr(8'h01);
    do_addr(8'h0D);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 reset clears selected", int'(selected), 0);
    do_data("R11 after reset", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6);
    // R1: selection holds across several data cycles
    do_addr(8'h01);
    do_data("R1 first", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    do_data("R1 second", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    #1;
    chk("R1 still selected", int'(selected), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule